// File: doc/BRIEF.md
# Cache Way Zero-Fill Command Issuer

This block is a small bus master. It makes an outer cache clear one of its ways over a fixed address range, so that the way can act as scratch RAM before main memory is ready. A single start pulse sets off a fixed series of register transactions on a simple valid/ready register port. First come four command writes. Next comes a read of the queue's error register, and the whole command is issued again whenever that read returns nonzero. After that the block polls the completion-status register until the done code appears, and finally acknowledges by writing the status value back.

Every register address, the fill base (stack top minus fill size), the fill size, the way mask, the mode word, the done code and the retry limit are parameters. The caller sees `busy_o` for the duration of the command and then a one-cycle `done_o` pulse. If the retry limit runs out, the caller gets a one-cycle `fail_o` pulse instead.

Top module: `wayfill_issuer`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o` and `bus_valid_o` are all low.
- R2: A `start_i` pulse while idle makes the first write to the mode register appear on the bus in the following cycle, with `busy_o` high.
- R3: The command writes are issued in the order mode, base, size, way-select, carrying 0x00408006, STACK_TOP minus FILL_SIZE, FILL_SIZE (default 0x8000) and WAY_MASK (default 0x00000100, way 8).
- R4: After the way-select write the block reads the error register. A nonzero value restarts the command with the mode write in the next cycle. A zero value moves on to status polling in the next cycle.
- R5: If the error register reads nonzero on MAX_RETRY+1 consecutive attempts, `fail_o` pulses for one cycle, `busy_o` drops, `done_o` stays low and no further transaction is issued.
- R6: The status register is read again and again until a read returns exactly DONE_CODE (0x4). Any other value, such as 0x0, 0x5 or 0xC, leads to another read.
- R7: Completion is acknowledged by writing the value just read (0x4) back to the status register.
- R8: `done_o` is high for exactly one cycle, the cycle after the acknowledge write completes, and `busy_o` is low in that cycle.
- R9: A request holds `bus_valid_o`, `bus_write_o`, `bus_addr_o` and `bus_wdata_o` steady until `bus_ready_i` is high. A transaction completes only in a cycle with both valid and ready high, and read data is taken only in that cycle.
- R10: `start_i` has no effect while a command is in progress. The transaction sequence is unchanged when it is held high.
- R11: `busy_o` is high from the cycle after start up to and including the cycle of the final handshake, and `bus_valid_o` is never high without `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | One-cycle pulse when the retry limit is exhausted |
| bus_valid_o | output | 1 | Register transaction request |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Register address |
| bus_wdata_o | output | DW | Write data |
| bus_ready_i | input | 1 | Target accepts the transaction this cycle |
| bus_rdata_i | input | DW | Read data, valid in the ready cycle |

## Verification
The first mode write is due in the cycle right after the clock edge that takes `start_i`. Each later request is due in the cycle right after the previous handshake, and `done_o` or `fail_o` is due in the cycle right after the last handshake. The bench keeps a queue of expected transactions built from the requirements. At every falling edge it compares valid, direction, address, data, busy, done and fail against the queue head, and it pops the head only in a cycle where it drives ready high. Ready is stretched by different periods, so the hold-until-ready timing and the one-cycle response after each handshake are both checked at those exact cycles.

// File: rtl/wf_pkg.sv
package wf_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WMODE,
      ST_WBASE,
      ST_WSIZE,
      ST_WWAY,
      ST_RERR,
      ST_RSTAT,
      ST_WACK,
      ST_DONE,
      ST_FAIL
   } wf_state_e;

   typedef enum logic [2:0] {
      RG_MODE,
      RG_BASE,
      RG_SIZE,
      RG_WAY,
      RG_ERR,
      RG_STAT
   } wf_reg_e;

endpackage

// File: rtl/wf_retry.sv
module wf_retry #(
   parameter int unsigned MAX_RETRY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic exhausted_o
);
   generate
      if (MAX_RETRY == 0) begin : g_no_retry
         assign exhausted_o = 1'b1;
      end else begin : g_counter
         localparam int unsigned CW = $clog2(MAX_RETRY + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt_q <= '0;
            else if (clr_i) cnt_q <= '0;
            else if (inc_i) cnt_q <= cnt_q + 1'b1;
         end
         assign exhausted_o = (cnt_q == CW'(MAX_RETRY));
      end
   endgenerate
endmodule

// File: rtl/wf_seq.sv
module wf_seq
   import wf_pkg::*;
#(
   parameter int unsigned DW = 32,
   parameter logic [DW-1:0] DONE_CODE = 'h4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          ack_i,
   input  logic [DW-1:0] rdata_i,
   input  logic          exhausted_i,
   output logic          req_vld_o,
   output logic          req_wr_o,
   output wf_reg_e       req_reg_o,
   output logic          retry_clr_o,
   output logic          retry_inc_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          fail_o
);
   wf_state_e st_q, st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d        = st_q;
      retry_clr_o = 1'b0;
      retry_inc_o = 1'b0;
      case (st_q)
         ST_IDLE:  if (start_i) begin
                      st_d        = ST_WMODE;
                      retry_clr_o = 1'b1;
                   end
         ST_WMODE: if (ack_i) st_d = ST_WBASE;
         ST_WBASE: if (ack_i) st_d = ST_WSIZE;
         ST_WSIZE: if (ack_i) st_d = ST_WWAY;
         ST_WWAY:  if (ack_i) st_d = ST_RERR;
         ST_RERR:  if (ack_i) begin
                      if (rdata_i == '0) begin
                         st_d = ST_RSTAT;
                      end else if (exhausted_i) begin
                         st_d = ST_FAIL;
                      end else begin
                         st_d        = ST_WMODE;
                         retry_inc_o = 1'b1;
                      end
                   end
         ST_RSTAT: if (ack_i && (rdata_i == DONE_CODE)) st_d = ST_WACK;
         ST_WACK:  if (ack_i) st_d = ST_DONE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      req_reg_o = RG_MODE;
      case (st_q)
         ST_WBASE: req_reg_o = RG_BASE;
         ST_WSIZE: req_reg_o = RG_SIZE;
         ST_WWAY:  req_reg_o = RG_WAY;
         ST_RERR:  req_reg_o = RG_ERR;
         ST_RSTAT: req_reg_o = RG_STAT;
         ST_WACK:  req_reg_o = RG_STAT;
         default:  req_reg_o = RG_MODE;
      endcase
   end

   assign req_vld_o = (st_q != ST_IDLE) && (st_q != ST_DONE) && (st_q != ST_FAIL);
   assign req_wr_o  = (st_q != ST_RERR) && (st_q != ST_RSTAT);
   assign busy_o    = req_vld_o;
   assign done_o    = (st_q == ST_DONE);
   assign fail_o    = (st_q == ST_FAIL);
endmodule

// File: rtl/wf_bus_port.sv
module wf_bus_port
   import wf_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32,
   parameter logic [AW-1:0] REG_MODE = 'h1000_0000,
   parameter logic [AW-1:0] REG_BASE = 'h1000_0004,
   parameter logic [AW-1:0] REG_SIZE = 'h1000_0008,
   parameter logic [AW-1:0] REG_WAY  = 'h1000_000C,
   parameter logic [AW-1:0] REG_ERR  = 'h1000_0010,
   parameter logic [AW-1:0] REG_STAT = 'h1000_0020,
   parameter logic [DW-1:0] MODE_WORD = 'h0040_8006,
   parameter logic [DW-1:0] BASE_WORD = 'h000F_8000,
   parameter logic [DW-1:0] SIZE_WORD = 'h0000_8000,
   parameter logic [DW-1:0] WAY_WORD  = 'h0000_0100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_vld_i,
   input  logic          req_wr_i,
   input  wf_reg_e       req_reg_i,
   output logic          ack_o,
   output logic          bus_valid_o,
   output logic          bus_write_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   input  logic          bus_ready_i,
   input  logic [DW-1:0] bus_rdata_i
);
   logic [DW-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rdata_q <= '0;
      else if (ack_o && !req_wr_i)    rdata_q <= bus_rdata_i;
   end

   always_comb begin
      bus_addr_o  = REG_MODE;
      bus_wdata_o = MODE_WORD;
      case (req_reg_i)
         RG_BASE: begin bus_addr_o = REG_BASE; bus_wdata_o = BASE_WORD; end
         RG_SIZE: begin bus_addr_o = REG_SIZE; bus_wdata_o = SIZE_WORD; end
         RG_WAY:  begin bus_addr_o = REG_WAY;  bus_wdata_o = WAY_WORD;  end
         RG_ERR:  begin bus_addr_o = REG_ERR;  bus_wdata_o = '0;        end
         RG_STAT: begin bus_addr_o = REG_STAT; bus_wdata_o = rdata_q;   end
         default: begin bus_addr_o = REG_MODE; bus_wdata_o = MODE_WORD; end
      endcase
   end

   assign bus_valid_o = req_vld_i;
   assign bus_write_o = req_wr_i;
   assign ack_o       = req_vld_i && bus_ready_i;
endmodule

// File: rtl/wayfill_issuer.sv
module wayfill_issuer
   import wf_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32,
   parameter logic [AW-1:0] REG_MODE  = 'h1000_0000,
   parameter logic [AW-1:0] REG_BASE  = 'h1000_0004,
   parameter logic [AW-1:0] REG_SIZE  = 'h1000_0008,
   parameter logic [AW-1:0] REG_WAY   = 'h1000_000C,
   parameter logic [AW-1:0] REG_ERR   = 'h1000_0010,
   parameter logic [AW-1:0] REG_STAT  = 'h1000_0020,
   parameter logic [DW-1:0] MODE_WORD = 'h0040_8006,
   parameter logic [AW-1:0] STACK_TOP = 'h0010_0000,
   parameter logic [AW-1:0] FILL_SIZE = 'h0000_8000,
   parameter logic [DW-1:0] WAY_MASK  = 'h0000_0100,
   parameter logic [DW-1:0] DONE_CODE = 'h0000_0004,
   parameter int unsigned   MAX_RETRY = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          fail_o,
   output logic          bus_valid_o,
   output logic          bus_write_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   input  logic          bus_ready_i,
   input  logic [DW-1:0] bus_rdata_i
);
   localparam logic [AW-1:0] FILL_BASE = STACK_TOP - FILL_SIZE;

   generate
      if (AW > DW) begin : g_bad_width
         $error("wayfill_issuer: AW must not exceed DW");
      end
      if (FILL_SIZE > STACK_TOP) begin : g_bad_range
         $error("wayfill_issuer: FILL_SIZE exceeds STACK_TOP");
      end
      if (DONE_CODE == '0) begin : g_bad_code
         $error("wayfill_issuer: DONE_CODE must be nonzero");
      end
   endgenerate

   logic    req_vld, req_wr, ack, exhausted, retry_clr, retry_inc;
   wf_reg_e req_reg;

   wf_seq #(.DW(DW), .DONE_CODE(DONE_CODE)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .ack_i      (ack),
      .rdata_i    (bus_rdata_i),
      .exhausted_i(exhausted),
      .req_vld_o  (req_vld),
      .req_wr_o   (req_wr),
      .req_reg_o  (req_reg),
      .retry_clr_o(retry_clr),
      .retry_inc_o(retry_inc),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .fail_o     (fail_o)
   );

   wf_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (retry_clr),
      .inc_i      (retry_inc),
      .exhausted_o(exhausted)
   );

   wf_bus_port #(
      .AW(AW), .DW(DW),
      .REG_MODE(REG_MODE), .REG_BASE(REG_BASE), .REG_SIZE(REG_SIZE),
      .REG_WAY(REG_WAY), .REG_ERR(REG_ERR), .REG_STAT(REG_STAT),
      .MODE_WORD(MODE_WORD),
      .BASE_WORD(DW'(FILL_BASE)),
      .SIZE_WORD(DW'(FILL_SIZE)),
      .WAY_WORD(WAY_MASK)
   ) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_vld_i  (req_vld),
      .req_wr_i   (req_wr),
      .req_reg_i  (req_reg),
      .ack_o      (ack),
      .bus_valid_o(bus_valid_o),
      .bus_write_o(bus_write_o),
      .bus_addr_o (bus_addr_o),
      .bus_wdata_o(bus_wdata_o),
      .bus_ready_i(bus_ready_i),
      .bus_rdata_i(bus_rdata_i)
   );
endmodule

// File: rtl/wayfill_issuer_chk.sv
module wayfill_issuer_chk #(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32,
   parameter logic [AW-1:0] REG_MODE  = 'h1000_0000,
   parameter logic [AW-1:0] REG_ERR   = 'h1000_0010,
   parameter logic [AW-1:0] REG_STAT  = 'h1000_0020,
   parameter logic [DW-1:0] DONE_CODE = 'h0000_0004
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          fail_o,
   input logic          bus_valid_o,
   input logic          bus_write_o,
   input logic [AW-1:0] bus_addr_o,
   input logic [DW-1:0] bus_wdata_o,
   input logic          bus_ready_i,
   input logic [DW-1:0] bus_rdata_i
);
   a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o)
                                      && $stable(bus_write_o) && $stable(bus_wdata_o));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && !bus_valid_o);

   a_r5_fail_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> !done_o && !busy_o && !bus_valid_o);

   a_r11_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_o |-> busy_o);

   a_r2_start_mode: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && !done_o && !fail_o |=>
         bus_valid_o && bus_write_o && bus_addr_o == REG_MODE);

   a_r7_ack_value: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_o && bus_write_o && bus_addr_o == REG_STAT |-> bus_wdata_o == DONE_CODE);

   a_r6_repoll: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_o && bus_ready_i && !bus_write_o && bus_addr_o == REG_STAT
      && bus_rdata_i != DONE_CODE |=> bus_valid_o && !bus_write_o && bus_addr_o == REG_STAT);

   a_r4_clean_to_poll: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_o && bus_ready_i && !bus_write_o && bus_addr_o == REG_ERR
      && bus_rdata_i == '0 |=> bus_valid_o && !bus_write_o && bus_addr_o == REG_STAT);
endmodule

bind wayfill_issuer wayfill_issuer_chk #(
   .AW(AW), .DW(DW), .REG_MODE(REG_MODE), .REG_ERR(REG_ERR),
   .REG_STAT(REG_STAT), .DONE_CODE(DONE_CODE)
) u_chk (.*);

// File: tb/tb_wayfill_issuer.sv
module tb_wayfill_issuer;
   localparam logic [31:0] A_MODE = 32'h5000_0040;
   localparam logic [31:0] A_BASE = 32'h5000_0044;
   localparam logic [31:0] A_SIZE = 32'h5000_0048;
   localparam logic [31:0] A_WAY  = 32'h5000_004C;
   localparam logic [31:0] A_ERR  = 32'h5000_0080;
   localparam logic [31:0] A_STAT = 32'h5000_00C0;
   localparam logic [31:0] TOP    = 32'h0020_0000;
   localparam logic [31:0] SIZE   = 32'h0000_8000;
   localparam int          RETRY  = 3;

   logic clk = 0, rst_n = 0, start = 0;
   logic busy, done, fail, valid, wr, ready = 0;
   logic [31:0] addr, wdata, rdata = 0;

   always #5 clk = ~clk;

   wayfill_issuer #(
      .AW(32), .DW(32), .REG_MODE(A_MODE), .REG_BASE(A_BASE), .REG_SIZE(A_SIZE),
      .REG_WAY(A_WAY), .REG_ERR(A_ERR), .REG_STAT(A_STAT), .MODE_WORD(32'h0040_8006),
      .STACK_TOP(TOP), .FILL_SIZE(SIZE), .WAY_MASK(32'h0000_0100),
      .DONE_CODE(32'h4), .MAX_RETRY(RETRY)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
      .fail_o(fail), .bus_valid_o(valid), .bus_write_o(wr), .bus_addr_o(addr),
      .bus_wdata_o(wdata), .bus_ready_i(ready), .bus_rdata_i(rdata)
   );

   typedef struct { bit w; logic [31:0] a; logic [31:0] d; } txn_t;
   txn_t expq[$];
   int checks = 0, errors = 0, cyc = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic string tag(txn_t t);
      if (t.a == A_STAT) return t.w ? "R7" : "R6";
      if (t.a == A_ERR)  return "R4";
      return "R3";
   endfunction

   // errv: error reads per attempt; statv: status reads (last must be 4)
   task automatic run(int errv[$], int statv[$], int period, bit hold_start);
      int att = 0, pol = 0, guard = 0;
      bit fails = 0;
      expq.delete();
      for (int a = 0; a < errv.size(); a++) begin
         expq.push_back('{1, A_MODE, 32'h0040_8006});
         expq.push_back('{1, A_BASE, TOP - SIZE});
         expq.push_back('{1, A_SIZE, SIZE});
         expq.push_back('{1, A_WAY, 32'h0000_0100});
         expq.push_back('{0, A_ERR, 32'h0});
         if (errv[a] != 0 && a == RETRY) fails = 1;
      end
      if (!fails) begin
         foreach (statv[i]) expq.push_back('{0, A_STAT, 32'h0});
         expq.push_back('{1, A_STAT, 32'h4});
      end
      start = 1;
      @(posedge clk); @(negedge clk);
      start = 0;
      chk("R2 busy after start", {31'b0, busy}, 32'h1);
      while (expq.size() > 0 && guard < 2000) begin
         txn_t h = expq[0];
         guard++;
         chk("R11 busy", {31'b0, busy}, 32'h1);
         chk("R9 valid", {31'b0, valid}, 32'h1);
         chk({tag(h), " dir"}, {31'b0, wr}, {31'b0, h.w});
         chk({tag(h), " addr"}, addr, h.a);
         if (h.w) chk({tag(h), " wdata"}, wdata, h.d);
         chk("R8 no early done", {30'b0, done, fail}, 32'h0);
         ready = ((cyc % period) == 0);
         rdata = 32'h0;
         if (!h.w && h.a == A_ERR)  rdata = errv[att];
         if (!h.w && h.a == A_STAT) rdata = statv[pol];
         if (ready) begin
            void'(expq.pop_front());
            if (!h.w && h.a == A_ERR)  att++;
            if (!h.w && h.a == A_STAT) pol++;
         end
         start = hold_start && (expq.size() > 0);
         @(posedge clk); @(negedge clk);
      end
      ready = 0; rdata = 0; start = 0;
      chk(fails ? "R5 fail pulse" : "R8 done pulse", {31'b0, fails ? fail : done}, 32'h1);
      chk(fails ? "R5 no done" : "R8 no fail", {31'b0, fails ? done : fail}, 32'h0);
      chk("R8 busy low at end", {30'b0, busy, valid}, 32'h0);
      @(posedge clk); @(negedge clk);
      chk("R8 single-cycle pulse", {30'b0, done, fail}, 32'h0);
      chk("R5 no further request", {31'b0, valid}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {28'b0, busy, done, fail, valid}, 32'h0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 idle after reset", {28'b0, busy, done, fail, valid}, 32'h0);
      run('{0}, '{4}, 1, 0);                    // R2 R3 R7 R8
      run('{1, 0}, '{0, 5, 12, 4}, 3, 1);       // R4 R6 R9 R10
      run('{7, 7, 7, 7}, '{4}, 2, 0);           // R5
      run('{0}, '{2, 4}, 1, 0);                 // R6 back-to-back
      run('{3, 3, 0}, '{4}, 4, 1);              // R4 retry within limit
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule